// File: doc/BRIEF.md
# Modular Matrix-Product Systolic Grid

This block computes C = A·B mod q on a small two-dimensional grid of processing elements (default 4 by 4). It serves number-theoretic transforms and residue-number-system base conversion once they are written as matrix products over a prime modulus. The caller first loads the modulus q and its Barrett constant mu = floor(2^64 / q). It then pulses `start` and streams the inner dimension one beat per cycle. Each beat carries column k of A, one lane per grid row, and row k of B, one lane per grid column. The block skews both streams internally so that row operands travel right and column operands travel down, one element per cycle.

Every element keeps its own accumulator and never passes it on. A beat passes through a six-register pipeline: an operand register, a full product, a Barrett quotient estimate, a remainder, a two-step correction, and finally a modular add into the accumulator. When the last beat has reached the far-corner element, the block pulses `done` and returns the accumulators one grid row per cycle. Accumulators keep their contents from one product to the next until `clr` is asserted. This lets a long inner dimension be split across several products.

Top module: `modsys_array`

## Requirements
- R1: After reset, `in_ready`, `done` and `res_valid` are all low.
- R2: A `cfg_we` pulse loads `cfg_mod` and `cfg_mu` only while the block is idle (not feeding, flushing or draining). A pulse at any other time leaves the modulus in use unchanged.
- R3: `start` while idle raises `in_ready` from the next cycle. A beat (`in_valid` high) is taken only while `in_ready` is high, and a beat offered while `in_ready` is low changes no accumulator.
- R4: Lane i of `in_a` (bits i*32 and up) carries A[i][k] and lane j of `in_b` carries B[k][j]. After a product, lane j of `res_data` in the row tagged `res_row`=i equals the prior accumulator plus the sum over k of A[i][k]·B[k][j], reduced mod q, and always lies in [0, q). Operands must be below q.
- R5: Results are exact for any odd modulus up to 2^31−1, including operands equal to q−1, when mu = floor(2^64/q).
- R6: `done` is a one-cycle pulse. It is high in the cycle that follows the clock edge ROWS+COLS+3 edges after the edge that accepts the beat with `in_last` high. This is 11 edges for the default grid.
- R7: Starting the cycle after `done`, the block presents rows 0 to ROWS−1 in ascending order on consecutive cycles, with `res_valid` high. `in_ready` stays low throughout.
- R8: Without `clr`, a new product adds onto the accumulators left by the previous one.
- R9: `clr` zeroes every accumulator. The add of beat k reaches element (i,j) on the edge that lies i+j+5 edges after the edge that accepted the beat. If that edge coincides with the `clr` edge, the accumulator takes that single reduced term. Earlier adds are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load modulus and Barrett constant (idle only) |
| cfg_mod | input | 32 | Modulus q, below 2^31 |
| cfg_mu | input | 64 | floor(2^64 / q) |
| clr | input | 1 | Zero all accumulators |
| start | input | 1 | Begin accepting beats |
| in_ready | output | 1 | Beats are being accepted |
| in_valid | input | 1 | Beat present on in_a / in_b |
| in_last | input | 1 | This beat ends the inner dimension |
| in_a | input | ROWS*32 | One A element per grid row |
| in_b | input | COLS*32 | One B element per grid column |
| done | output | 1 | All accumulators final |
| res_valid | output | 1 | res_data holds one grid row |
| res_row | output | $clog2(ROWS) | Index of the grid row on res_data |
| res_data | output | COLS*32 | One accumulator per grid column |

## Verification
The test focuses on a clear and an accumulator add that land on the same clock edge. Because each element sees its terms on a staggered schedule, a clear raised during the feed meets each element at a different place in its stream. The bench asserts `clr` alongside a chosen beat after an earlier, uncleared product. For every element it predicts which terms survive, keeping exactly those whose add edge is not before the clear edge. It then compares every drained value with that prediction. Sweeps over several moduli and inner lengths, near-maximal operands, and a modulus write during the feed surround this case.

// File: rtl/modsys_pkg.sv
package modsys_pkg;
    localparam int DW        = 32;      // operand and modulus width
    localparam int PW        = 2 * DW;  // full product width
    localparam int MW        = 2 * DW;  // Barrett constant width
    localparam int PE_STAGES = 6;       // operand reg .. accumulator

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FEED,
        PH_FLUSH,
        PH_DRAIN
    } phase_e;
endpackage

// File: rtl/modsys_skew.sv
module modsys_skew #(
    parameter int DEPTH = 1,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_delay
            logic [DEPTH-1:0][WIDTH-1:0] sh_d, sh_q;

            always_comb begin
                sh_d[0] = din;
                for (int s = 1; s < DEPTH; s++) sh_d[s] = sh_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '0;
                else        sh_q <= sh_d;
            end

            assign dout = sh_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/modsys_pe.sv
module modsys_pe
    import modsys_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [DW-1:0] mod_q,
    input  logic [MW-1:0] mod_mu,
    input  logic [DW-1:0] op_a,    // already registered in the grid (stage 1)
    input  logic [DW-1:0] op_b,
    input  logic          op_v,
    output logic [DW-1:0] acc
);
    localparam int WW = PW + MW;

    typedef struct packed {
        logic [PW-1:0]   prod;   // stage 2
        logic            v2;
        logic [PW-1:0]   prod3;  // stage 3
        logic [DW:0]     qhat;
        logic            v3;
        logic [DW+1:0]   rem;    // stage 4
        logic            v4;
        logic [DW-1:0]   red;    // stage 5
        logic            v5;
        logic [DW-1:0]   acc;    // stage 6
    } pe_s;

    pe_s st_d, st_q;

    logic [WW-1:0]   wide;
    logic [PW-1:0]   qmul;
    logic [DW+1:0]   q_ext, r1, r2;
    logic [DW-1:0]   base;
    logic [DW:0]     sum, sum_c;

    always_comb begin
        st_d     = st_q;
        q_ext    = {2'b00, mod_q};

        st_d.prod = PW'(op_a) * PW'(op_b);
        st_d.v2   = op_v;

        wide       = WW'(st_q.prod) * WW'(mod_mu);
        st_d.qhat  = wide[MW +: DW+1];
        st_d.prod3 = st_q.prod;
        st_d.v3    = st_q.v2;

        qmul      = PW'(st_q.qhat) * PW'(mod_q);
        st_d.rem  = st_q.prod3[DW+1:0] - qmul[DW+1:0];
        st_d.v4   = st_q.v3;

        r1        = (st_q.rem >= q_ext) ? st_q.rem - q_ext : st_q.rem;
        r2        = (r1 >= q_ext) ? r1 - q_ext : r1;
        st_d.red  = r2[DW-1:0];
        st_d.v5   = st_q.v4;

        base  = clr ? '0 : st_q.acc;
        sum   = {1'b0, base} + {1'b0, st_q.red};
        sum_c = (sum >= {1'b0, mod_q}) ? sum - {1'b0, mod_q} : sum;
        st_d.acc = st_q.v5 ? sum_c[DW-1:0] : base;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc = st_q.acc;
endmodule

// File: rtl/modsys_ctrl.sv
module modsys_ctrl
    import modsys_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [DW-1:0]           cfg_mod,
    input  logic [MW-1:0]           cfg_mu,
    input  logic                    start,
    input  logic                    in_valid,
    input  logic                    in_last,
    output logic                    in_ready,
    output logic                    accept,
    output logic                    drain_en,
    output logic [$clog2(ROWS)-1:0] drain_row,
    output logic                    done,
    output logic                    res_valid,
    output logic [$clog2(ROWS)-1:0] res_row,
    output logic [DW-1:0]           mod_q,
    output logic [MW-1:0]           mod_mu
);
    localparam int RW        = $clog2(ROWS);
    localparam int FLUSH_LEN = ROWS + COLS - 2 + PE_STAGES - 1;
    localparam int CW        = $clog2(FLUSH_LEN + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic [DW-1:0] mod;
        logic [MW-1:0] mu;
        logic          done;
        logic          rv;
        logic [RW-1:0] row;
    } ctrl_s;

    ctrl_s c_d, c_q;

    assign in_ready  = (c_q.ph == PH_FEED);
    assign accept    = in_ready && in_valid;
    assign drain_en  = (c_q.ph == PH_DRAIN);
    assign drain_row = c_q.cnt[RW-1:0];

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.rv   = drain_en;
        c_d.row  = drain_row;
        unique case (c_q.ph)
            PH_IDLE: begin
                if (cfg_we) begin
                    c_d.mod = cfg_mod;
                    c_d.mu  = cfg_mu;
                end
                if (start) c_d.ph = PH_FEED;
            end
            PH_FEED: begin
                if (accept && in_last) begin
                    c_d.ph  = PH_FLUSH;
                    c_d.cnt = '0;
                end
            end
            PH_FLUSH: begin
                if (c_q.cnt == CW'(FLUSH_LEN - 1)) begin
                    c_d.ph   = PH_DRAIN;
                    c_d.cnt  = '0;
                    c_d.done = 1'b1;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            PH_DRAIN: begin
                if (c_q.cnt == CW'(ROWS - 1)) begin
                    c_d.ph  = PH_IDLE;
                    c_d.cnt = '0;
                end else begin
                    c_d.cnt = c_q.cnt + 1'b1;
                end
            end
            default: c_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign done      = c_q.done;
    assign res_valid = c_q.rv;
    assign res_row   = c_q.row;
    assign mod_q     = c_q.mod;
    assign mod_mu    = c_q.mu;
endmodule

// File: rtl/modsys_array.sv
module modsys_array
    import modsys_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [DW-1:0]           cfg_mod,
    input  logic [MW-1:0]           cfg_mu,
    input  logic                    clr,
    input  logic                    start,
    output logic                    in_ready,
    input  logic                    in_valid,
    input  logic                    in_last,
    input  logic [ROWS*DW-1:0]      in_a,
    input  logic [COLS*DW-1:0]      in_b,
    output logic                    done,
    output logic                    res_valid,
    output logic [$clog2(ROWS)-1:0] res_row,
    output logic [COLS*DW-1:0]      res_data
);
    localparam int RW = $clog2(ROWS);

    logic          accept, drain_en;
    logic [RW-1:0] drain_row;
    logic [DW-1:0] mod_q;
    logic [MW-1:0] mod_mu;

    modsys_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_mod(cfg_mod), .cfg_mu(cfg_mu),
        .start(start), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .accept(accept),
        .drain_en(drain_en), .drain_row(drain_row),
        .done(done), .res_valid(res_valid), .res_row(res_row),
        .mod_q(mod_q), .mod_mu(mod_mu)
    );

    // Input skew: row i waits i cycles, column j waits j cycles.
    logic [ROWS-1:0][DW:0]   row_feed;
    logic [COLS-1:0][DW-1:0] col_feed;

    for (genvar i = 0; i < ROWS; i++) begin : g_rskew
        modsys_skew #(.DEPTH(i), .WIDTH(DW + 1)) u_skew (
            .clk(clk), .rst_n(rst_n),
            .din({accept, in_a[i*DW +: DW]}),
            .dout(row_feed[i])
        );
    end

    for (genvar j = 0; j < COLS; j++) begin : g_cskew
        modsys_skew #(.DEPTH(j), .WIDTH(DW)) u_skew (
            .clk(clk), .rst_n(rst_n),
            .din(in_b[j*DW +: DW]),
            .dout(col_feed[j])
        );
    end

    // Operand fabric (PE stage 1) and drain register.
    typedef struct packed {
        logic [ROWS-1:0][COLS-1:0][DW-1:0] opa;
        logic [ROWS-1:0][COLS-1:0][DW-1:0] opb;
        logic [ROWS-1:0][COLS-1:0]         opv;
        logic [COLS-1:0][DW-1:0]           res;
    } grid_s;

    grid_s g_d, g_q;
    logic [ROWS-1:0][COLS-1:0][DW-1:0] acc_w;

    always_comb begin
        g_d = g_q;
        for (int i = 0; i < ROWS; i++) begin
            g_d.opa[i][0] = row_feed[i][DW-1:0];
            g_d.opv[i][0] = row_feed[i][DW];
            for (int j = 1; j < COLS; j++) begin
                g_d.opa[i][j] = g_q.opa[i][j-1];
                g_d.opv[i][j] = g_q.opv[i][j-1];
            end
        end
        for (int j = 0; j < COLS; j++) begin
            g_d.opb[0][j] = col_feed[j];
            for (int i = 1; i < ROWS; i++) g_d.opb[i][j] = g_q.opb[i-1][j];
        end
        if (drain_en) g_d.res = acc_w[drain_row];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    for (genvar i = 0; i < ROWS; i++) begin : g_row
        for (genvar j = 0; j < COLS; j++) begin : g_col
            modsys_pe u_pe (
                .clk(clk), .rst_n(rst_n), .clr(clr),
                .mod_q(mod_q), .mod_mu(mod_mu),
                .op_a(g_q.opa[i][j]), .op_b(g_q.opb[i][j]),
                .op_v(g_q.opv[i][j]),
                .acc(acc_w[i][j])
            );
        end
    end

    assign res_data = g_q.res;
endmodule

// File: rtl/modsys_array_chk.sv
module modsys_array_chk
    import modsys_pkg::*;
#(
    parameter int ROWS = 4,
    parameter int COLS = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    done,
    input logic                    in_ready,
    input logic                    res_valid,
    input logic [$clog2(ROWS)-1:0] res_row,
    input logic [COLS*DW-1:0]      res_data,
    input logic [DW-1:0]           mod_q
);
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DRAIN_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (res_valid && res_row == '0)); // R7

    AST_ROW_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_row != ($clog2(ROWS))'(ROWS - 1))
        |=> (res_valid && res_row == $past(res_row) + 1'b1)); // R7

    AST_NO_FEED_WHILE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !in_ready); // R3

    AST_MOD_HELD_IN_FEED: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> $stable(mod_q)); // R2

    for (genvar j = 0; j < COLS; j++) begin : g_rng
        AST_RESULT_BELOW_Q: assert property (@(posedge clk) disable iff (!rst_n)
            res_valid |-> (res_data[j*DW +: DW] < mod_q)); // R4
    end
endmodule

bind modsys_array modsys_array_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .in_ready(in_ready),
    .res_valid(res_valid), .res_row(res_row), .res_data(res_data),
    .mod_q(mod_q)
);

// File: tb/modsys_array_bench.sv
module modsys_array_bench;
    localparam int ROWS = 4;
    localparam int COLS = 4;
    localparam int DW   = 32;
    localparam int KMAX = 8;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_we = 1'b0;
    logic [DW-1:0]           cfg_mod = '0;
    logic [2*DW-1:0]         cfg_mu = '0;
    logic                    clr = 1'b0;
    logic                    start = 1'b0;
    logic                    in_ready;
    logic                    in_valid = 1'b0;
    logic                    in_last = 1'b0;
    logic [ROWS*DW-1:0]      in_a = '0;
    logic [COLS*DW-1:0]      in_b = '0;
    logic                    done;
    logic                    res_valid;
    logic [$clog2(ROWS)-1:0] res_row;
    logic [COLS*DW-1:0]      res_data;

    modsys_array #(.ROWS(ROWS), .COLS(COLS)) u_modsys_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mod(cfg_mod),
        .cfg_mu(cfg_mu), .clr(clr), .start(start), .in_ready(in_ready),
        .in_valid(in_valid), .in_last(in_last), .in_a(in_a), .in_b(in_b),
        .done(done), .res_valid(res_valid), .res_row(res_row),
        .res_data(res_data)
    );

    always #2ns clk = ~clk;   // 250 MHz

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    longint unsigned cur_q;
    longint unsigned A [ROWS][KMAX];
    longint unsigned B [KMAX][COLS];
    longint unsigned e [ROWS][COLS];
    logic [COLS*DW-1:0] got [ROWS];
    int unsigned seed = 32'h1357_9bdf;

    int rows_seen, order_err, done_cnt, done_cyc, first_cyc;

    always @(negedge clk) begin
        if (done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
        if (res_valid) begin
            if (int'(res_row) != rows_seen) order_err = order_err + 1;
            if (rows_seen == 0) first_cyc = cyc;
            got[res_row] = res_data;
            rows_seen = rows_seen + 1;
        end
    end

    task automatic check(input string req, input longint unsigned act,
                         input longint unsigned exp, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int unsigned nxt();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic cfg_load(input longint unsigned qv);
        logic [64:0] num;
        logic [64:0] mu;
        num = 65'd1 << 64;
        mu  = num / 65'(qv);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mod = qv[DW-1:0]; cfg_mu = mu[63:0];
        @(negedge clk);
        cfg_we = 1'b0;
        cur_q = qv;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) e[i][j] = 0;
    endtask

    // One product of inner length K; clr_at >= 0 raises clr with that beat;
    // bad_q != 0 attempts a modulus write during the feed.
    task automatic run(input int K, input int clr_at, input longint unsigned bad_q,
                       input bit maxfill, input string tag);
        int drive_cyc;
        int w;
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < K; k++) A[i][k] = maxfill ? cur_q - 1 : nxt() % cur_q;
        for (int k = 0; k < K; k++)
            for (int j = 0; j < COLS; j++) B[k][j] = maxfill ? cur_q - 1 : nxt() % cur_q;
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                if (clr_at >= 0) e[i][j] = 0;
                for (int k = 0; k < K; k++)
                    if (clr_at < 0 || k + i + j + 5 >= clr_at)
                        e[i][j] = (e[i][j] + (A[i][k] * B[k][j]) % cur_q) % cur_q;
            end
        rows_seen = 0; order_err = 0; done_cnt = 0; done_cyc = -1; first_cyc = -1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R3", longint'(in_ready), 1, "in_ready after start");
        for (int k = 0; k < K; k++) begin
            in_valid = 1'b1;
            in_last  = (k == K - 1);
            clr      = (k == clr_at);
            cfg_we   = (k == 0 && bad_q != 0);
            if (bad_q != 0) begin
                cfg_mod = bad_q[DW-1:0];
                cfg_mu  = 64'd12345;
            end
            for (int i = 0; i < ROWS; i++) in_a[i*DW +: DW] = A[i][k][DW-1:0];
            for (int j = 0; j < COLS; j++) in_b[j*DW +: DW] = B[k][j][DW-1:0];
            drive_cyc = cyc;
            @(negedge clk);
            clr = 1'b0; cfg_we = 1'b0;
        end
        in_valid = 1'b0; in_last = 1'b0;
        w = 0;
        while (rows_seen < ROWS && w < 100) begin
            @(negedge clk);
            w++;
        end
        check("R6", done_cnt, 1, "done pulses per product");
        check("R6", done_cyc, drive_cyc + 12, "done cycle");
        check("R7", first_cyc, drive_cyc + 13, "first drained row cycle");
        check("R7", order_err, 0, "row order errors");
        check("R7", rows_seen, ROWS, "rows drained");
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                check(tag, longint'(got[i][j*DW +: DW]), e[i][j],
                      $sformatf("C[%0d][%0d] K=%0d q=%0d", i, j, K, cur_q));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: quiet outputs in reset and just after release
        check("R1", longint'(in_ready), 0, "in_ready in reset");
        check("R1", longint'(done), 0, "done in reset");
        check("R1", longint'(res_valid), 0, "res_valid in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1", longint'(in_ready), 0, "in_ready after reset");

        // Sweep: several moduli and inner lengths (R4, R5)
        begin
            longint unsigned qs [5] = '{17, 97, 65537, 1000000007, 2147483647};
            int ks [3] = '{1, 3, 8};
            foreach (qs[qi]) begin
                cfg_load(qs[qi]);
                foreach (ks[ki]) begin
                    clear_all();
                    run(ks[ki], -1, 0, 1'b0, (qs[qi] > 32'h4000_0000) ? "R5" : "R4");
                end
            end
        end

        // R5: operands at q-1 for the largest modulus
        clear_all();
        run(8, -1, 0, 1'b1, "R5");

        // R8: second product accumulates onto the first
        cfg_load(65521);
        clear_all();
        run(4, -1, 0, 1'b0, "R4");
        run(5, -1, 0, 1'b0, "R8");

        // R9: clr meets staggered adds mid-feed, after uncleared data
        run(8, 6, 0, 1'b0, "R9");
        run(8, 7, 0, 1'b0, "R9");
        run(3, 0, 0, 1'b0, "R9");

        // R2: modulus write attempted during feed is ignored
        cfg_load(1000003);
        clear_all();
        run(6, -1, 101, 1'b0, "R2");

        // R3: beats offered while idle change nothing
        clear_all();
        @(negedge clk);
        in_valid = 1'b1; in_last = 1'b1;
        in_a = {ROWS{32'd999}}; in_b = {COLS{32'd777}};
        repeat (4) @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        check("R3", longint'(in_ready), 0, "in_ready stays low while idle");
        run(2, -1, 0, 1'b0, "R3");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog run did not finish actual=%0d expected<150000 cycles", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule